// File: doc/BRIEF.md
# Addressed Serial Settings Receiver

This block receives the control side of a three-wire serial port (data, bit clock and an active-low frame enable) for a stereo audio processor. All three pins are brought into a fast system clock domain through synchronizer flops, and their edges are detected there. While the enable is low, each rising edge of the bit clock shifts one data bit in. The first two bits of a frame form a device address. The most recent nine bits sit in a sliding window. When the enable returns high, a frame with a matching address and enough bits is executed: a 3-bit function code picks one of eight settings and a 6-bit value is written to it.

The eight settings are input select, bass, treble, volume and four faders (left/right, front/rear). Each setting is kept as a registered output with only its meaningful bits. A registered mute flag is raised while volume is at its lowest code and no input is selected. Codes are passed on unchanged. Turning them into attenuation or boost is left to the analog side.

Top module: `serial_setting_bank`

## Requirements
- R1: After reset, volume and the four faders read 0, bass and treble read 0110 (flat), input select reads 000 (open), and mute is 1.
- R2: A frame of exactly 11 bits, sent most significant bit first as address 1,0 then function f[2:0] then value v[5:0], writes v to the setting picked by f. The function codes are 000 input select, 001 bass, 010 treble, 011 volume, 100 right front fader, 101 left front fader, 110 right rear fader and 111 left rear fader.
- R3: A frame whose first two bits are not 1 then 0 changes no setting. This holds even when the previous frame was addressed correctly.
- R4: A correctly addressed frame longer than 11 bits executes only the final nine bits received before the enable rises. The bits between the address and those nine bits have no effect.
- R5: A correctly addressed frame shorter than 11 bits changes no setting.
- R6: No setting changes before the enable rises. Bit-clock edges while the enable is high change no setting.
- R7: A frame whose enable falls while the bit clock is high changes no setting.
- R8: Each setting keeps only its low bits: volume bits [5:0], bass and treble bits [3:0], faders bits [4:0] and input select bits [2:0]. The upper value bits are dropped.
- R9: Mute reads 1 exactly when volume is 000000 and input select is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial data pin |
| ser_clk | input | 1 | Serial bit clock pin |
| ser_en_n | input | 1 | Active-low frame enable pin |
| vol_o | output | 6 | Volume code |
| treble_o | output | 4 | Treble code |
| bass_o | output | 4 | Bass code |
| fade_lf_o | output | 5 | Left front fader code |
| fade_rf_o | output | 5 | Right front fader code |
| fade_lr_o | output | 5 | Left rear fader code |
| fade_rr_o | output | 5 | Right rear fader code |
| in_sel_o | output | 3 | Input select code |
| mute_o | output | 1 | Mute flag |

## Verification
The enable rising at the pin reaches the outputs on the fourth system clock edge after it: two synchronizer stages, one edge-detect and commit stage, and one settings register. The mute flag updates on that same edge. The bench drives every pin just after a falling system edge. For each frame it samples the settings three falling edges after the enable rises, when they must still hold the old values. It samples them again six falling edges after the rise, when they must show the new values. Every serial bit is held for ten system cycles on each clock phase, so the synchronized bit clock and data settle well before they are sampled.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int FUNC_W = 3;
  localparam int VAL_W  = 6;
  localparam int N_SET  = 1 << FUNC_W;

  typedef enum logic [FUNC_W-1:0] {
    FN_INSEL  = 3'd0,
    FN_BASS   = 3'd1,
    FN_TREBLE = 3'd2,
    FN_VOLUME = 3'd3,
    FN_FD_RF  = 3'd4,
    FN_FD_LF  = 3'd5,
    FN_FD_RR  = 3'd6,
    FN_FD_LR  = 3'd7
  } ssb_func_e;

  localparam logic [VAL_W-1:0] TONE_FLAT = 6'b000110;

  // Bits of the value field that a setting keeps
  function automatic logic [VAL_W-1:0] ssb_mask(input int f);
    case (f)
      0:       return 6'b000111;
      1, 2:    return 6'b001111;
      3:       return 6'b111111;
      default: return 6'b011111;
    endcase
  endfunction

  // Power-on code of a setting
  function automatic logic [VAL_W-1:0] ssb_default(input int f);
    if (f == 1 || f == 2) return TONE_FLAT;
    return '0;
  endfunction
endpackage

// File: rtl/ssb_sync.sv
module ssb_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/ssb_frame_rx.sv
module ssb_frame_rx
  import ssb_pkg::*;
#(
  parameter int               ADDR_W   = 2,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 2'b10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_s,
  input  logic              sclk_s,
  input  logic              en_n_s,
  output logic              commit_o,
  output logic [FUNC_W-1:0] func_o,
  output logic [VAL_W-1:0]  val_o
);
  localparam int WIN_W     = FUNC_W + VAL_W;
  localparam int MIN_FRAME = ADDR_W + WIN_W;
  localparam int CNT_W     = $clog2(MIN_FRAME + 1);

  logic              sclk_q, en_q;
  logic              active, addr_ok;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_sh;
  logic [WIN_W-1:0]  win;

  wire sclk_rise = sclk_s & ~sclk_q;
  wire en_fall   = ~en_n_s & en_q;
  wire en_rise   = en_n_s & ~en_q;
  wire cnt_full  = (cnt == CNT_W'(MIN_FRAME));

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      en_q     <= 1'b1;
      active   <= 1'b0;
      addr_ok  <= 1'b0;
      cnt      <= '0;
      addr_sh  <= '0;
      win      <= '0;
      commit_o <= 1'b0;
      func_o   <= '0;
      val_o    <= '0;
    end else begin
      sclk_q   <= sclk_s;
      en_q     <= en_n_s;
      commit_o <= 1'b0;
      if (en_fall) begin
        active  <= ~sclk_s;
        addr_ok <= 1'b0;
        cnt     <= '0;
      end else if (en_rise) begin
        commit_o <= active & addr_ok & cnt_full;
        func_o   <= win[WIN_W-1 -: FUNC_W];
        val_o    <= win[VAL_W-1:0];
        active   <= 1'b0;
      end else if (active && !en_n_s && sclk_rise) begin
        win <= {win[WIN_W-2:0], data_s};
        if (!cnt_full) cnt <= cnt + 1'b1;
        if (cnt < CNT_W'(ADDR_W)) addr_sh <= {addr_sh[ADDR_W-2:0], data_s};
        if (cnt == CNT_W'(ADDR_W - 1))
          addr_ok <= ({addr_sh[ADDR_W-2:0], data_s} == DEV_ADDR);
      end
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MIN_FRAME));

  // R6
  single_commit_chk: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !commit_o);
endmodule

// File: rtl/ssb_settings.sv
module ssb_settings
  import ssb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [VAL_W-1:0]  val_i,
  output logic [VAL_W-1:0]  set_o [N_SET],
  output logic              mute_o
);
  logic [VAL_W-1:0] set_q   [N_SET];
  logic [VAL_W-1:0] set_nxt [N_SET];

  for (genvar g = 0; g < N_SET; g++) begin : g_set
    assign set_nxt[g] = (wr_i && func_i == FUNC_W'(g)) ? (val_i & ssb_mask(g)) : set_q[g];
    always_ff @(posedge clk) begin
      if (rst) set_q[g] <= ssb_default(g);
      else     set_q[g] <= set_nxt[g];
    end
    assign set_o[g] = set_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) mute_o <= 1'b1;
    else     mute_o <= (set_nxt[FN_VOLUME] == '0) && (set_nxt[FN_INSEL] == '0);
  end

  // R8
  tone_width_chk: assert property (@(posedge clk) disable iff (rst)
    set_q[FN_BASS][VAL_W-1:4] == '0 && set_q[FN_TREBLE][VAL_W-1:4] == '0);
endmodule

// File: rtl/serial_setting_bank.sv
module serial_setting_bank
  import ssb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ser_data,
  input  logic       ser_clk,
  input  logic       ser_en_n,
  output logic [5:0] vol_o,
  output logic [3:0] treble_o,
  output logic [3:0] bass_o,
  output logic [4:0] fade_lf_o,
  output logic [4:0] fade_rf_o,
  output logic [4:0] fade_lr_o,
  output logic [4:0] fade_rr_o,
  output logic [2:0] in_sel_o,
  output logic       mute_o
);
  logic [2:0]        pins_s;
  logic              commit;
  logic [FUNC_W-1:0] func;
  logic [VAL_W-1:0]  val;
  logic [VAL_W-1:0]  set_v [N_SET];

  ssb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({ser_data, ser_clk, ser_en_n}),
    .dout(pins_s)
  );

  ssb_frame_rx u_rx (
    .clk     (clk),
    .rst     (rst),
    .data_s  (pins_s[2]),
    .sclk_s  (pins_s[1]),
    .en_n_s  (pins_s[0]),
    .commit_o(commit),
    .func_o  (func),
    .val_o   (val)
  );

  ssb_settings u_set (
    .clk   (clk),
    .rst   (rst),
    .wr_i  (commit),
    .func_i(func),
    .val_i (val),
    .set_o (set_v),
    .mute_o(mute_o)
  );

  assign in_sel_o  = set_v[FN_INSEL][2:0];
  assign bass_o    = set_v[FN_BASS][3:0];
  assign treble_o  = set_v[FN_TREBLE][3:0];
  assign vol_o     = set_v[FN_VOLUME];
  assign fade_rf_o = set_v[FN_FD_RF][4:0];
  assign fade_lf_o = set_v[FN_FD_LF][4:0];
  assign fade_rr_o = set_v[FN_FD_RR][4:0];
  assign fade_lr_o = set_v[FN_FD_LR][4:0];

  // R6
  hold_without_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable({vol_o, treble_o, bass_o, fade_lf_o, fade_rf_o,
                         fade_lr_o, fade_rr_o, in_sel_o}));

  // R9
  mute_match_chk: assert property (@(posedge clk) disable iff (rst)
    mute_o == (vol_o == 6'd0 && in_sel_o == 3'd0));
endmodule

// File: tb/test_serial_setting_bank.sv
module test_serial_setting_bank;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_en_n = 1'b1;
  logic [5:0] vol_o;
  logic [3:0] treble_o, bass_o;
  logic [4:0] fade_lf_o, fade_rf_o, fade_lr_o, fade_rr_o;
  logic [2:0] in_sel_o;
  logic       mute_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [5:0] exp_set [8];

  always #2.5 clk = ~clk;

  serial_setting_bank i_serial_setting_bank (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk), .ser_en_n(ser_en_n),
    .vol_o(vol_o), .treble_o(treble_o), .bass_o(bass_o),
    .fade_lf_o(fade_lf_o), .fade_rf_o(fade_rf_o), .fade_lr_o(fade_lr_o),
    .fade_rr_o(fade_rr_o), .in_sel_o(in_sel_o), .mute_o(mute_o)
  );

  function automatic logic [5:0] keep_bits(input int f);
    case (f)
      0: return 6'h07;
      1, 2: return 6'h0F;
      3: return 6'h3F;
      default: return 6'h1F;
    endcase
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic em;
    em = (exp_set[3] == 6'd0) && (exp_set[0] == 6'd0);
    chk(req, "in_sel", {5'd0, in_sel_o}, {2'd0, exp_set[0]});
    chk(req, "bass",   {4'd0, bass_o},   {2'd0, exp_set[1]});
    chk(req, "treble", {4'd0, treble_o}, {2'd0, exp_set[2]});
    chk(req, "vol",    {2'd0, vol_o},    {2'd0, exp_set[3]});
    chk(req, "fd_rf",  {3'd0, fade_rf_o}, {2'd0, exp_set[4]});
    chk(req, "fd_lf",  {3'd0, fade_lf_o}, {2'd0, exp_set[5]});
    chk(req, "fd_rr",  {3'd0, fade_rr_o}, {2'd0, exp_set[6]});
    chk(req, "fd_lr",  {3'd0, fade_lr_o}, {2'd0, exp_set[7]});
    chk("R9", "mute", {7'd0, mute_o}, {7'd0, em});
  endtask

  // frame is right-aligned, len bits, sent MSB first
  task automatic send_frame(input logic [63:0] frame, input int len, input bit bad_fall, input string req);
    int f;
    cyc(1);
    ser_clk = bad_fall; ser_en_n = 1'b1;
    cyc(HALF);
    ser_en_n = 1'b0;
    cyc(HALF);
    ser_clk = 1'b0;
    for (int i = 0; i < len; i++) begin
      ser_data = frame[len-1-i];
      cyc(HALF);
      ser_clk = 1'b1;
      cyc(HALF);
      ser_clk = 1'b0;
    end
    cyc(HALF);
    check_all("R6");            // nothing applied while enable low
    ser_en_n = 1'b1;
    cyc(3);
    check_all("R6");            // not yet visible three edges after the rise
    if (!bad_fall && len >= 11 && frame[len-1 -: 2] == 2'b10) begin
      f = int'(frame[8:6]);
      exp_set[f] = frame[5:0] & keep_bits(f);
    end
    cyc(3);
    check_all(req);
  endtask

  task automatic clocks_while_idle(input int n);
    ser_en_n = 1'b1;
    for (int i = 0; i < n; i++) begin
      ser_data = i[0];
      cyc(HALF); ser_clk = 1'b1; cyc(HALF); ser_clk = 1'b0;
    end
    cyc(6);
    check_all("R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED);
    for (int f = 0; f < 8; f++) exp_set[f] = (f == 1 || f == 2) ? 6'd6 : 6'd0;
    cyc(5);
    rst = 1'b0;
    cyc(3);
    check_all("R1");

    // R2: every function code once
    for (int f = 0; f < 8; f++)
      send_frame({53'd0, 2'b10, 3'(f), 6'(f * 5 + 3) & keep_bits(f)}, 11, 1'b0, "R2");
    // R8: upper bits dropped
    send_frame({53'd0, 2'b10, 3'd1, 6'b111010}, 11, 1'b0, "R8");
    send_frame({53'd0, 2'b10, 3'd6, 6'b111111}, 11, 1'b0, "R8");
    send_frame({53'd0, 2'b10, 3'd0, 6'b111101}, 11, 1'b0, "R8");
    // R9: mute set and cleared
    send_frame({53'd0, 2'b10, 3'd3, 6'd0}, 11, 1'b0, "R9");
    send_frame({53'd0, 2'b10, 3'd0, 6'd0}, 11, 1'b0, "R9");
    send_frame({53'd0, 2'b10, 3'd0, 6'd2}, 11, 1'b0, "R9");
    send_frame({53'd0, 2'b10, 3'd0, 6'd0}, 11, 1'b0, "R9");
    // R3: bad addresses, right after a good frame
    send_frame({53'd0, 2'b01, 3'd3, 6'd40}, 11, 1'b0, "R3");
    send_frame({53'd0, 2'b11, 3'd2, 6'd9}, 11, 1'b0, "R3");
    send_frame({53'd0, 2'b00, 3'd5, 6'd17}, 11, 1'b0, "R3");
    // R4: long frame, only the last nine bits count
    send_frame({48'd0, 2'b10, 5'b11011, 3'd7, 6'd21}, 16, 1'b0, "R4");
    send_frame({44'd0, 2'b10, 3'd3, 6'd63, 3'd3, 6'd42}, 20, 1'b0, "R4");
    // R5: short frames
    send_frame({54'd0, 2'b10, 3'd3, 5'd31}, 10, 1'b0, "R5");
    send_frame({57'd0, 2'b10, 3'd4, 2'd3}, 7, 1'b0, "R5");
    // R7: enable falls with bit clock high
    send_frame({53'd0, 2'b10, 3'd3, 6'd50}, 11, 1'b1, "R7");
    // R6: edges with enable high
    clocks_while_idle(11);

    for (int n = 0; n < 120; n++) begin
      int len;
      logic [63:0] fr;
      bit bad;
      len = 9 + int'($urandom % 12);
      fr = {$urandom, $urandom};
      if ($urandom % 5 != 0) fr[len-1 -: 2] = 2'b10;
      fr = fr & ((64'd1 << len) - 64'd1);
      bad = ($urandom % 10 == 0);
      send_frame(fr, len, bad, "R2");
      if (n % 30 == 0) clocks_while_idle(4);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule